// File: doc/BRIEF.md
# Bus-Invert Transition Encoder and Decoder

This block reduces switching activity on a wide parallel synchronous bus. On the sending side it keeps a register holding the encoded word currently on the lines. When a new word arrives with its valid strobe, the encoder counts how many data lines would change if that word were sent unmodified. If more than half would change, it sends the bitwise complement instead. An extra polarity line records which form was sent.

The receiving side XORs every data line with the polarity line to recover the original word. The encoder always compares against the encoded value that was actually driven, not the previous raw word. On an exact half-width tie it keeps the existing polarity, so the polarity line does not toggle. The data width and the structure of the transition counter are parameters. The decoder sits in the same top level, so a link can be checked end to end.

Top module: `businv_link`

## Requirements
- R1: While reset is asserted, the encoded bus register is all zeros and the polarity line is 0.
- R2: In a cycle where `in_valid` is low, the encoded bus and the polarity line keep their values at the next edge, whatever `in_data` holds.
- R3: One cycle after a word is accepted, `out_data` equals that word. `out_data` is `bus_data` XOR the polarity bit copied across all lines.
- R4: For every accepted word, the number of `bus_data` lines that change at the following edge is at most floor(DATA_W/2).
- R5: If the number of bits that differ between the current `bus_data` and the new word is more than DATA_W/2, the next `bus_data` is the complement of the word and `bus_inv` is 1.
- R6: If that difference count is exactly DATA_W/2, `bus_inv` keeps its current value and `bus_data` is the word XOR that polarity.
- R7: If that difference count is below DATA_W/2, the word is sent unmodified and `bus_inv` is 0.
- R8: The difference count uses the encoded value on `bus_data`, not the previous raw word. Example: after sending all ones from reset (result: bus all zeros, polarity 1), sending all zeros gives polarity 0.
- R9: At a width of 9, with the bus holding 110011101 and the next word 000100110, the encoder drives 111011001 with polarity 1. That changes 2 data lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Qualifies `in_data` for encoding in this cycle |
| in_data | input | DATA_W | Raw word to transmit |
| bus_data | output | DATA_W | Encoded data lines as driven |
| bus_inv | output | 1 | Polarity line; 1 means `bus_data` carries the complement |
| out_data | output | DATA_W | Word recovered by the receiving-side decoder |

## Verification
The assertions check the following on every cycle:
- the reset state;
- holding while idle;
- the toggle bound;
- the three polarity cases (above, at and below half width);
- end-to-end recovery of each word one cycle after it is accepted.

The bench's own scenarios are the only way to show some behaviours:
- that the comparison uses the encoded history and not the raw history, shown with a word sequence where the two give different decisions;
- the exact 9-bit worked case;
- that a tie leaves an existing polarity of 1 in place.

Long runs of random words show that the toggle bound holds across many inversion decisions in a row.

// File: rtl/businv_pkg.sv
package businv_pkg;
   // transition-counter structure choices
   localparam int POP_CHAIN = 0;  // single accumulation chain
   localparam int POP_SPLIT = 1;  // two half-width chains summed at the end

   function automatic int cnt_width(input int w);
      return $clog2(w + 1);
   endfunction
endpackage

// File: rtl/businv_popcnt.sv
module businv_popcnt
   import businv_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int STYLE  = POP_SPLIT,
   parameter int CNT_W  = cnt_width(DATA_W)
) (
   input  logic [DATA_W-1:0] vec,
   output logic [CNT_W-1:0]  cnt
);
   generate
      if (STYLE != POP_CHAIN && STYLE != POP_SPLIT) begin : g_bad_style
         $error("businv_popcnt: unknown STYLE %0d", STYLE);
      end
      if (STYLE == POP_CHAIN) begin : g_chain
         always_comb begin
            cnt = '0;
            for (int i = 0; i < DATA_W; i++) begin
               cnt = cnt + CNT_W'(vec[i]);
            end
         end
      end else begin : g_split
         localparam int LO_W = DATA_W / 2;
         localparam int HI_W = DATA_W - LO_W;
         logic [CNT_W-1:0] lo_sum, hi_sum;
         always_comb begin
            lo_sum = '0;
            for (int i = 0; i < LO_W; i++) begin
               lo_sum = lo_sum + CNT_W'(vec[i]);
            end
         end
         always_comb begin
            hi_sum = '0;
            for (int j = 0; j < HI_W; j++) begin
               hi_sum = hi_sum + CNT_W'(vec[LO_W + j]);
            end
         end
         assign cnt = lo_sum + hi_sum;
      end
   endgenerate
endmodule

// File: rtl/businv_enc.sv
module businv_enc
   import businv_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int POP_STYLE = POP_SPLIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] bus_q,
   output logic              inv_q
);
   localparam int CNT_W = cnt_width(DATA_W);
   localparam int HALF  = DATA_W / 2;
   localparam logic [CNT_W:0] W_EXT = (CNT_W+1)'(DATA_W);

   logic [DATA_W-1:0] diff;
   logic [CNT_W-1:0]  flips;
   logic [CNT_W:0]    flips_x2;
   logic              inv_next;

   assign diff     = bus_q ^ in_data;
   assign flips_x2 = {flips, 1'b0};

   businv_popcnt #(.DATA_W(DATA_W), .STYLE(POP_STYLE), .CNT_W(CNT_W)) u_pop (
      .vec (diff),
      .cnt (flips)
   );

   always_comb begin
      if (flips_x2 > W_EXT)       inv_next = 1'b1;
      else if (flips_x2 == W_EXT) inv_next = inv_q;
      else                        inv_next = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_q <= '0;
         inv_q <= 1'b0;
      end else if (in_valid) begin
         bus_q <= in_data ^ {DATA_W{inv_next}};
         inv_q <= inv_next;
      end
   end

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(bus_q) && $stable(inv_q)));

   assert_toggle_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ($countones(bus_q ^ $past(bus_q)) <= HALF));

   assert_invert_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (2 * $countones(bus_q ^ in_data) > DATA_W))
      |=> (inv_q && bus_q == ~$past(in_data)));

   assert_tie_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (2 * $countones(bus_q ^ in_data) == DATA_W))
      |=> $stable(inv_q));

   assert_true_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (2 * $countones(bus_q ^ in_data) < DATA_W))
      |=> (!inv_q && bus_q == $past(in_data)));
endmodule

// File: rtl/businv_dec.sv
module businv_dec #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_inv,
   output logic [DATA_W-1:0] data
);
   assign data = bus_data ^ {DATA_W{bus_inv}};
endmodule

// File: rtl/businv_link.sv
module businv_link
   import businv_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int POP_STYLE = POP_SPLIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_inv,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("businv_link: DATA_W must be at least 2, got %0d", DATA_W);
      end
   endgenerate

   businv_enc #(.DATA_W(DATA_W), .POP_STYLE(POP_STYLE)) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .bus_q    (bus_data),
      .inv_q    (bus_inv)
   );

   businv_dec #(.DATA_W(DATA_W)) u_dec (
      .bus_data (bus_data),
      .bus_inv  (bus_inv),
      .data     (out_data)
   );

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (bus_data == '0 && !bus_inv));

   assert_recover_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_data == $past(in_data)));
endmodule

// File: tb/businv_link_tb.sv
module businv_link_tb;
   localparam int W    = 16;
   localparam int HALF = W / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  in_data = '0;
   logic [W-1:0]  bus_data, out_data;
   logic          bus_inv;

   logic          v9 = 1'b0;
   logic [8:0]    d9 = '0;
   logic [8:0]    b9, o9;
   logic          i9;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   businv_link #(.DATA_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .bus_data(bus_data), .bus_inv(bus_inv), .out_data(out_data)
   );

   businv_link #(.DATA_W(9), .POP_STYLE(0)) u_dut9 (
      .clk(clk), .rst_n(rst_n), .in_valid(v9), .in_data(d9),
      .bus_data(b9), .bus_inv(i9), .out_data(o9)
   );

   typedef struct {
      logic [W-1:0] data;
      logic [W-1:0] bus;
      logic         inv;
      logic [W-1:0] prev_bus;
      string        tag;
   } item_t;

   item_t        sb[$];
   logic [W-1:0] m_bus = '0;
   logic         m_inv = 1'b0;
   logic [W-1:0] m_last = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: compute expected encoding from the requirements, push, drive
   task automatic send(input logic [W-1:0] d, input string tag);
      item_t it;
      int c;
      c = $countones(m_bus ^ d);
      it.prev_bus = m_bus;
      if (2 * c > W)       m_inv = 1'b1;   // R5
      else if (2 * c < W)  m_inv = 1'b0;   // R7
      // tie: keep m_inv (R6)
      m_bus   = d ^ {W{m_inv}};
      m_last  = d;
      it.data = d; it.bus = m_bus; it.inv = m_inv; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         in_data = W'($urandom);
         @(negedge clk);
      end
      chk(bus_data == m_bus, "R2 idle bus", 32'(bus_data), 32'(m_bus));
      chk(bus_inv == m_inv, "R2 idle polarity", 32'(bus_inv), 32'(m_inv));
      chk(out_data == m_last, "R2 idle decode", 32'(out_data), 32'(m_last));
   endtask

   // monitor: pops one expected item per accepted word
   always @(posedge clk) begin
      if (rst_n && in_valid) begin
         item_t it;
         #5;
         if (sb.size() == 0) begin
            chk(1'b0, "R3 scoreboard underflow", 32'd0, 32'd1);
         end else begin
            it = sb.pop_front();
            chk(out_data == it.data, {"R3 decode ", it.tag}, 32'(out_data), 32'(it.data));
            chk(bus_data == it.bus, {"R5/R7 bus ", it.tag}, 32'(bus_data), 32'(it.bus));
            chk(bus_inv == it.inv, {"R6 polarity ", it.tag}, 32'(bus_inv), 32'(it.inv));
            chk($countones(bus_data ^ it.prev_bus) <= HALF, {"R4 toggles ", it.tag},
                32'($countones(bus_data ^ it.prev_bus)), 32'(HALF));
         end
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state, sampled while reset still asserted
      chk(bus_data == '0, "R1 reset bus", 32'(bus_data), 32'd0);
      chk(bus_inv == 1'b0, "R1 reset polarity", 32'(bus_inv), 32'd0);
      chk(b9 == '0 && i9 == 1'b0, "R1 reset bus 9-bit", 32'({i9, b9}), 32'd0);
      rst_n = 1'b1;

      // R9: 9-bit worked case on the second instance
      @(negedge clk); v9 = 1'b1; d9 = 9'b000011101;
      @(negedge clk); d9 = 9'b110011101;
      @(negedge clk);
      chk(b9 == 9'b110011101 && !i9, "R9 setup bus", 32'({i9, b9}), 32'(9'b110011101));
      d9 = 9'b000100110;
      @(negedge clk);
      v9 = 1'b0;
      chk(b9 == 9'b111011001, "R9 complement sent", 32'(b9), 32'(9'b111011001));
      chk(i9 == 1'b1, "R9 polarity", 32'(i9), 32'd1);
      chk(o9 == 9'b000100110, "R9 decode", 32'(o9), 32'(9'b000100110));

      // R8: encoded-history comparison; then R6 tie with polarity held at 1
      send('1, "R8 all ones");
      send('0, "R8 zeros after inverted ones");
      idle(2);
      chk(bus_inv == 1'b0, "R8 polarity after zeros", 32'(bus_inv), 32'd0);
      send('1, "R6 set polarity");
      send(16'h00FF, "R6 tie keep 1");
      idle(1);
      chk(bus_inv == 1'b1 && bus_data == 16'hFF00, "R6 tie result",
          32'({bus_inv, bus_data}), 32'({1'b1, 16'hFF00}));
      send(16'h0F0F, "R6 tie again");
      send(16'h0001, "R7 small change");

      // R2: idle with changing data
      idle(5);

      // mixed patterns
      send(16'hAAAA, "pattern alt");
      send(16'h5555, "pattern alt inv");
      send(16'hFFFE, "pattern near ones");
      send(16'h8000, "pattern single");
      for (int k = 0; k < 300; k++) begin
         send(W'($urandom), "random");
         if (k % 37 == 0) idle(2);
      end
      idle(3);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule